// File: doc/BRIEF.md
# Retentive Accumulating Timer

The block adds up the time its run input spends high, across any number of separate active periods. Time is measured in ticks: a one-cycle strobe from an outside tick source. While run is high, each tick adds one to the stored total. When run drops, counting pauses and the total is kept. When run returns, counting picks up from the kept total, not from zero.

The total stops growing once it reaches the preset. The done output is high only when the total has reached the preset and run is high in the same cycle. The total goes back to zero only through a synchronous reset or a dedicated clear input. A controller uses it to let a process advance after a set amount of active time, even if the process was interrupted along the way.

Top module: `retentive_accum_timer`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets the accumulated count to zero.
- R2: When run is high and a tick arrives, the count rises by exactly one at that clock edge. This applies when clear is low and the count is below the preset.
- R3: In a cycle with no tick, the count does not change unless clear or reset is applied.
- R4: When run is low, ticks do not change the count. The kept value is the starting point when run returns high.
- R5: Once the count is at or above the preset, further ticks leave it unchanged.
- R6: done equals (count >= preset, unsigned) AND run. It is combinational on the present count, preset and run.
- R7: A high clear sets the count to zero at the next edge. When clear and a tick arrive in the same cycle, clear wins.
- R8: A preset at or below the current count counts as reached, which includes a preset of zero. In that case done follows run directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle time-base strobe |
| run | input | 1 | Run input; high means time is being accumulated |
| clr | input | 1 | Synchronous clear of the accumulated count |
| preset | input | WIDTH | Target total in ticks |
| done | output | 1 | Total reached AND run |
| acc | output | WIDTH | Accumulated count |

## Verification
The checker watches every cycle for single-step growth on a qualified tick, a frozen count when run is low or no tick arrives, saturation at the preset, clear winning over a tick, and done never being high without run or without the preset reached. Only the bench scenarios can show that a total built up over several interrupted run periods arrives at the right value. The same goes for the exact cycle when done rises, and for a preset lowered below the kept total making done follow run. These are compared against a reference model in the bench, under random and directed input sequences.

// File: rtl/rat_pkg.sv
package rat_pkg;

  // Action applied to the accumulator at the next clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_ZERO = 2'd2
  } acc_act_e;

  // Picks the accumulator action; zeroing outranks stepping.
  function automatic acc_act_e pick_action(input logic zero_req,
                                           input logic step_req);
    if (zero_req)      return ACT_ZERO;
    else if (step_req) return ACT_STEP;
    else               return ACT_HOLD;
  endfunction

endpackage

// File: rtl/rat_qualify.sv
module rat_qualify
  import rat_pkg::*;
(
  input  logic     rst,
  input  logic     tick,
  input  logic     run,
  input  logic     clr,
  input  logic     reached,
  output logic     adv_evt,
  output logic     zero_evt,
  output acc_act_e act
);

  always_comb begin
    zero_evt = rst | clr;
    adv_evt  = tick & run & ~reached & ~zero_evt;
    act      = pick_action(zero_evt, adv_evt);
  end

endmodule

// File: rtl/rat_counter.sv
module rat_counter
  import rat_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  acc_act_e         act,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  function automatic logic [WIDTH-1:0] next_count(input acc_act_e a,
                                                  input logic [WIDTH-1:0] cur);
    case (a)
      ACT_ZERO: return '0;
      ACT_STEP: return cur + ONE;
      default:  return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    count <= next_count(act, count);
  end

endmodule

// File: rtl/rat_compare.sv
module rat_compare #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] preset,
  input  logic             run,
  output logic             reached,
  output logic             done
);

  function automatic logic at_or_past(input logic [WIDTH-1:0] c,
                                      input logic [WIDTH-1:0] p);
    return (c >= p);
  endfunction

  always_comb begin
    reached = at_or_past(count, preset);
    done    = reached & run;
  end

endmodule

// File: rtl/retentive_accum_timer.sv
module retentive_accum_timer
  import rat_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [WIDTH-1:0] preset,
  output logic             done,
  output logic [WIDTH-1:0] acc
);

  logic     adv_evt;
  logic     zero_evt;
  logic     reached;
  acc_act_e act;

  rat_qualify u_qual (
    .rst      (rst),
    .tick     (tick),
    .run      (run),
    .clr      (clr),
    .reached  (reached),
    .adv_evt  (adv_evt),
    .zero_evt (zero_evt),
    .act      (act)
  );

  rat_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk   (clk),
    .act   (act),
    .count (acc)
  );

  rat_compare #(.WIDTH(WIDTH)) u_cmp (
    .count   (acc),
    .preset  (preset),
    .run     (run),
    .reached (reached),
    .done    (done)
  );

endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             clr,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] acc,
  input logic             done,
  input logic             adv_evt,
  input logic             zero_evt
);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> acc == '0);

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !clr && acc < preset) |=> acc == $past(acc) + WIDTH'(1));

  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(acc));

  a_r4_run_low_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(acc));

  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (!clr && acc >= preset) |=> $stable(acc));

  a_r6_done_needs_run: assert property (@(posedge clk) disable iff (rst)
    done |-> (run && acc >= preset));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);

  a_r7_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({adv_evt, zero_evt}) <= 1);

  a_r8_low_preset_done: assert property (@(posedge clk) disable iff (rst)
    (run && acc >= preset) |-> done);

endmodule

bind retentive_accum_timer rat_checker #(.WIDTH(WIDTH)) u_rat_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .run      (run),
  .clr      (clr),
  .preset   (preset),
  .acc      (acc),
  .done     (done),
  .adv_evt  (adv_evt),
  .zero_evt (zero_evt)
);

// File: tb/retentive_accum_timer_test.sv
module retentive_accum_timer_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0, run = 1'b0, clr = 1'b0;
  logic [W-1:0] preset = W'(5);
  logic         done;
  logic [W-1:0] acc;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_acc = '0;

  always #4 clk = ~clk;

  retentive_accum_timer #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .clr(clr),
    .preset(preset), .done(done), .acc(acc)
  );

  function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
      input logic r, input logic c, input logic t, input logic ru,
      input logic [W-1:0] p);
    if (r || c) return '0;
    if (t && ru && (cur < p)) return cur + 1'b1;
    return cur;
  endfunction

  function automatic logic model_done(input logic [W-1:0] cur,
      input logic ru, input logic [W-1:0] p);
    return ru && !(cur < p);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got,
                     input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic ru, input logic c,
                      input logic [W-1:0] p, input string req);
    @(negedge clk);
    tick = t; run = ru; clr = c; preset = p;
    m_acc = model_next(m_acc, rst, c, t, ru, p);
    @(posedge clk);
    #1;
    chk({req, " acc"}, acc, m_acc);
    chk({req, " done"}, W'(done), W'(model_done(m_acc, ru, p)));
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    rst = 1'b1; tick = 1'b1; run = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; tick = 1'b0; run = 1'b0;
    #1;
    chk("R1 acc after reset", acc, '0);
    chk("R1 done low", W'(done), '0);
    m_acc = '0;

    // R2 / R4: interrupted accumulation toward preset 5
    step(1, 1, 0, 5, "R2");
    step(1, 1, 0, 5, "R2");
    step(1, 0, 0, 5, "R4 run low tick ignored");
    step(1, 0, 0, 5, "R4 run low tick ignored");
    step(0, 1, 0, 5, "R3 no tick");
    step(0, 1, 0, 5, "R3 no tick");
    step(1, 1, 0, 5, "R4 resume");
    step(1, 1, 0, 5, "R2");
    step(1, 1, 0, 5, "R6 done rises");
    step(1, 1, 0, 5, "R5 saturated");
    step(1, 1, 0, 5, "R5 saturated");
    step(0, 0, 0, 5, "R6 done drops with run");
    step(0, 1, 0, 5, "R6 done returns with run");
    // R8: lowered preset
    step(0, 1, 0, 2, "R8 preset below acc");
    step(0, 0, 0, 2, "R8 run low");
    // R7: clear with tick, clear wins
    step(1, 1, 1, 9, "R7 clear beats tick");
    step(1, 1, 0, 9, "R7 counting after clear");
    // R8: preset zero, done follows run
    step(0, 0, 1, 0, "R8 preset zero clear");
    step(0, 1, 0, 0, "R8 preset zero run high");
    step(1, 1, 0, 0, "R8 preset zero no step");
    step(0, 0, 0, 0, "R8 preset zero run low");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] p;
      p = (i % 200 == 0) ? W'($urandom_range(0, 40)) : preset;
      step(($urandom_range(0, 99) < 55), ($urandom_range(0, 99) < 70),
           ($urandom_range(0, 999) < 8), p, "R2 random");
    end

    // R1: mid-run reset
    @(negedge clk); rst = 1'b1; tick = 1'b1; run = 1'b1; preset = W'(50);
    @(posedge clk); #1;
    m_acc = '0;
    chk("R1 mid-run reset acc", acc, '0);
    @(negedge clk); rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule